// File: doc/BRIEF.md
# Product-Term ALU Slice with Carry Lookahead

This block is one slice of a programmable logic array with nine cells. Every cell builds two operands from product terms, which are ANDs of chosen true and complement literals from a shared 24-bit input plane. Each operand is the OR of some private terms and some selected terms from a pool of twelve that all cells share. A per-cell ALU combines the two operands. In logic mode it reads a four-entry truth table. In arithmetic mode it acts as a one-bit full adder or subtractor on a carry chain that ripples from cell to cell.

A flat lookahead network computes the slice's carry-out from the cells' generate and propagate signals. A higher slice can therefore take its carry without waiting on the ripple.

Behind each ALU sits a register. It can be made transparent. It captures on the slice clock when its selected clock source is high. It can be overridden by set and reset terms, and it loads a per-cell preload bit on an initialization strobe. Four extra product terms per cell supply the clock, output enable, set and reset. Each cell also drives a feedback line. This line can be forced high while the cell's output is disabled, so several cells can share one wired line.

Top module: `ptfb_slice`

## Requirements
- R1: A product term is the AND of its selected literals, where bit k of the true mask selects x_i[k] and bit k of the complement mask selects its inverse. A term with no literal selected is 0. Operand A is the OR of private terms 0..3 and the shared terms 0..3 enabled by the cell's A-select bits. Operand B is the OR of private term 4 and the shared terms 4..11 enabled by the cell's B-select bits.
- R2: In logic mode a cell's ALU result is lut[{A,B}], so the table index is 2*A+B.
- R3: In arithmetic mode the result is A xor B' xor cin, where B' is B inverted when the cell's subtract bit is set. Cell i+1 takes its carry from cell i. Cell 0 takes carry_i when carry_sel_i is 1, and otherwise takes its own subtract bit.
- R4: With all nine cells subtracting and carry_sel_i at 0, cell_o is (a-b) mod 512 and carry_o is 1 exactly when a >= b.
- R5: carry_o, from the lookahead network, always equals the carry leaving cell 8. A cell in logic mode neither generates nor propagates a carry.
- R6: A transparent cell shows its ALU result on cell_o in the same cycle.
- R7: A cell's clock select takes one of four codes: 0 is fclk0_i, 1 is fclk1_i, 2 is the cell's clock term (term 5), and 3 is none. The register captures the ALU result at a clock edge while the selected source is high, and holds otherwise.
- R8: The set term (term 7) drives cell_o to 1 and the reset term (term 8) drives it to 0 at once. Both also write the register at the edge. Reset wins over set.
- R9: rst_n clears every register. An edge with init_i high loads each register from its preload bit unless set or reset is active.
- R10: oe_o follows the cell's output-enable term (term 6). When that term has no literal selected, oe_o is 1.
- R11: When a cell's feedback-gate bit is set and its oe_o is 0, fb_o is 1. Otherwise fb_o equals cell_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slice clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Initialization strobe that loads preload bits |
| fclk0_i | input | 1 | Global clock source 0, used as a capture qualifier |
| fclk1_i | input | 1 | Global clock source 1, used as a capture qualifier |
| x_i | input | 24 | AND-plane literal inputs |
| carry_i | input | 1 | Carry from the slice below |
| carry_sel_i | input | 1 | 1: cell 0 takes carry_i; 0: cell 0 takes its subtract bit |
| sh_lit_t_i | input | 288 | True-literal masks of the 12 shared terms |
| sh_lit_c_i | input | 288 | Complement-literal masks of the 12 shared terms |
| cell_cfg_i | input | 9*CFG_W | Per-cell configuration records, cell 0 in the low bits |
| cell_o | output | 9 | Cell outputs |
| oe_o | output | 9 | Per-cell output enables |
| fb_o | output | 9 | Per-cell feedback lines |
| carry_o | output | 1 | Lookahead carry-out of the slice |

## Verification
A wrong carry anywhere in the chain shows up in the same cycle as a wrong sum bit or a wrong carry_o on the transparent outputs. The add and subtract sweeps over many operand pairs expose such errors. A broken truth-table index or operand OR shows up at once on cell_o for the affected input pattern. A register that captures on the wrong source, misses an override or loses its preload shows up on cell_o one edge after the triggering stimulus. A fault in the enable or feedback gating is visible on oe_o or fb_o in the same cycle that the enable term changes.

// File: rtl/ptfb_pkg.sv
package ptfb_pkg;
    localparam int PT_IN  = 24;
    localparam int N_SH   = 12;
    localparam int A_SH   = 4;
    localparam int N_TERM = 9;
    localparam int T_B    = 4;
    localparam int T_CLK  = 5;
    localparam int T_OE   = 6;
    localparam int T_SET  = 7;
    localparam int T_RST  = 8;

    typedef enum logic [1:0] {
        CK_G0   = 2'd0,
        CK_G1   = 2'd1,
        CK_TERM = 2'd2,
        CK_NONE = 2'd3
    } ck_sel_e;

    typedef struct packed {
        logic [N_TERM-1:0][PT_IN-1:0] lit_t;
        logic [N_TERM-1:0][PT_IN-1:0] lit_c;
        logic [A_SH-1:0]              a_sh;
        logic [N_SH-A_SH-1:0]         b_sh;
        logic [3:0]                   lut;
        logic                         arith;
        logic                         sub;
        ck_sel_e                      ck_sel;
        logic                         transp;
        logic                         fb_gate;
        logic                         preload;
    } cell_cfg_t;

    typedef struct packed {
        logic alu_f;
        logic g;
        logic p;
        logic clk_t;
        logic oe_t;
        logic set_t;
        logic rst_t;
    } cell_out_t;
endpackage

// File: rtl/ptfb_term.sv
module ptfb_term #(
    parameter int   W         = 24,
    parameter logic EMPTY_VAL = 1'b0
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] lit_t,
    input  logic [W-1:0] lit_c,
    output logic         term_o
);
    logic used;
    logic hit;

    always_comb begin
        used   = |(lit_t | lit_c);
        hit    = &((~lit_t | x) & (~lit_c | ~x));
        term_o = used ? hit : EMPTY_VAL;
    end
endmodule

// File: rtl/ptfb_cell.sv
module ptfb_cell
    import ptfb_pkg::*;
(
    input  logic [PT_IN-1:0] x,
    input  cell_cfg_t        cfg,
    input  logic [N_SH-1:0]  sh_term,
    input  logic             cin,
    output cell_out_t        co,
    output logic             cout
);
    logic [N_TERM-1:0] pt;
    logic opa, opb, opb_eff;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        localparam logic EV = (t == T_OE) ? 1'b1 : 1'b0;
        ptfb_term #(.W(PT_IN), .EMPTY_VAL(EV)) u_term (
            .x      (x),
            .lit_t  (cfg.lit_t[t]),
            .lit_c  (cfg.lit_c[t]),
            .term_o (pt[t])
        );
    end

    always_comb begin
        opa     = (|pt[T_B-1:0]) | (|(sh_term[A_SH-1:0] & cfg.a_sh));
        opb     = pt[T_B] | (|(sh_term[N_SH-1:A_SH] & cfg.b_sh));
        opb_eff = opb ^ cfg.sub;
        co       = '0;
        co.clk_t = pt[T_CLK];
        co.oe_t  = pt[T_OE];
        co.set_t = pt[T_SET];
        co.rst_t = pt[T_RST];
        if (cfg.arith) begin
            co.g     = opa & opb_eff;
            co.p     = opa ^ opb_eff;
            co.alu_f = co.p ^ cin;
        end else begin
            co.alu_f = cfg.lut[{opa, opb}];
        end
        cout = co.g | (co.p & cin);
    end
endmodule

// File: rtl/ptfb_lookahead.sv
module ptfb_lookahead #(
    parameter int N = 9
) (
    input  logic [N-1:0] g,
    input  logic [N-1:0] p,
    input  logic         cin,
    output logic         cout
);
    logic span;

    always_comb begin
        cout = (&p) & cin;
        for (int i = 0; i < N; i++) begin
            span = 1'b1;
            for (int j = i + 1; j < N; j++) begin
                span = span & p[j];
            end
            cout = cout | (g[i] & span);
        end
    end
endmodule

// File: rtl/ptfb_slice.sv
module ptfb_slice
    import ptfb_pkg::*;
#(
    parameter  int NCELL = 9,
    localparam int CFG_W = $bits(cell_cfg_t)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    init_i,
    input  logic                    fclk0_i,
    input  logic                    fclk1_i,
    input  logic [PT_IN-1:0]        x_i,
    input  logic                    carry_i,
    input  logic                    carry_sel_i,
    input  logic [N_SH*PT_IN-1:0]   sh_lit_t_i,
    input  logic [N_SH*PT_IN-1:0]   sh_lit_c_i,
    input  logic [NCELL*CFG_W-1:0]  cell_cfg_i,
    output logic [NCELL-1:0]        cell_o,
    output logic [NCELL-1:0]        oe_o,
    output logic [NCELL-1:0]        fb_o,
    output logic                    carry_o
);
    typedef struct packed {
        logic [NCELL-1:0] q;
    } state_t;

    state_t st_d, st_q;

    logic [N_SH-1:0]  sh_term;
    cell_cfg_t        cfg   [NCELL];
    cell_out_t        co    [NCELL];
    logic [NCELL-1:0] cin_w, cout_w;
    logic [NCELL-1:0] alu_v, g_v, p_v, clkt_v, oe_v, set_v, rst_v;
    logic [NCELL-1:0] pre_v, trn_v, fbg_v, cap_v;

    for (genvar s = 0; s < N_SH; s++) begin : g_shared
        ptfb_term #(.W(PT_IN), .EMPTY_VAL(1'b0)) u_sh (
            .x      (x_i),
            .lit_t  (sh_lit_t_i[s*PT_IN +: PT_IN]),
            .lit_c  (sh_lit_c_i[s*PT_IN +: PT_IN]),
            .term_o (sh_term[s])
        );
    end

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        assign cfg[c] = cell_cfg_t'(cell_cfg_i[c*CFG_W +: CFG_W]);
        if (c == 0) begin : g_first
            assign cin_w[c] = carry_sel_i ? carry_i : cfg[c].sub;
        end else begin : g_next
            assign cin_w[c] = cout_w[c-1];
        end
        ptfb_cell u_cell (
            .x       (x_i),
            .cfg     (cfg[c]),
            .sh_term (sh_term),
            .cin     (cin_w[c]),
            .co      (co[c]),
            .cout    (cout_w[c])
        );
        assign alu_v[c]  = co[c].alu_f;
        assign g_v[c]    = co[c].g;
        assign p_v[c]    = co[c].p;
        assign clkt_v[c] = co[c].clk_t;
        assign oe_v[c]   = co[c].oe_t;
        assign set_v[c]  = co[c].set_t;
        assign rst_v[c]  = co[c].rst_t;
        assign pre_v[c]  = cfg[c].preload;
        assign trn_v[c]  = cfg[c].transp;
        assign fbg_v[c]  = cfg[c].fb_gate;
    end

    ptfb_lookahead #(.N(NCELL)) u_la (
        .g    (g_v),
        .p    (p_v),
        .cin  (cin_w[0]),
        .cout (carry_o)
    );

    always_comb begin
        st_d  = st_q;
        cap_v = '0;
        for (int i = 0; i < NCELL; i++) begin
            unique case (cfg[i].ck_sel)
                CK_G0:   cap_v[i] = fclk0_i;
                CK_G1:   cap_v[i] = fclk1_i;
                CK_TERM: cap_v[i] = clkt_v[i];
                default: cap_v[i] = 1'b0;
            endcase
            if (rst_v[i])       st_d.q[i] = 1'b0;
            else if (set_v[i])  st_d.q[i] = 1'b1;
            else if (init_i)    st_d.q[i] = pre_v[i];
            else if (cap_v[i])  st_d.q[i] = alu_v[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < NCELL; i++) begin
            if (rst_v[i])       cell_o[i] = 1'b0;
            else if (set_v[i])  cell_o[i] = 1'b1;
            else if (trn_v[i])  cell_o[i] = alu_v[i];
            else                cell_o[i] = st_q.q[i];
            fb_o[i] = (fbg_v[i] && !oe_v[i]) ? 1'b1 : cell_o[i];
        end
        oe_o = oe_v;
    end
endmodule

// File: rtl/ptfb_slice_chk.sv
module ptfb_slice_chk #(
    parameter int NCELL = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_i,
    input logic             carry_o,
    input logic             ripple_top,
    input logic [NCELL-1:0] cell_o,
    input logic [NCELL-1:0] fb_o,
    input logic [NCELL-1:0] oe_o,
    input logic [NCELL-1:0] set_v,
    input logic [NCELL-1:0] rst_v,
    input logic [NCELL-1:0] cap_v,
    input logic [NCELL-1:0] pre_v,
    input logic [NCELL-1:0] fbg_v,
    input logic [NCELL-1:0] q_v
);
    assert_lookahead_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o == ripple_top);

    assert_reset_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_v & cell_o) == '0);

    assert_set_drives_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v & ~rst_v & ~cell_o) == '0);

    assert_fb_forced_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fbg_v & ~oe_o & ~fb_o) == '0);

    assert_init_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (((q_v ^ $past(pre_v)) & ~$past(set_v | rst_v)) == '0));

    assert_hold_no_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> (((q_v ^ $past(q_v)) & ~$past(cap_v | set_v | rst_v)) == '0));
endmodule

bind ptfb_slice ptfb_slice_chk #(.NCELL(NCELL)) u_ptfb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_i),
    .carry_o    (carry_o),
    .ripple_top (cout_w[NCELL-1]),
    .cell_o     (cell_o),
    .fb_o       (fb_o),
    .oe_o       (oe_o),
    .set_v      (set_v),
    .rst_v      (rst_v),
    .cap_v      (cap_v),
    .pre_v      (pre_v),
    .fbg_v      (fbg_v),
    .q_v        (st_q.q)
);

// File: tb/test_ptfb_slice.sv
`timescale 1ns/1ps
module test_ptfb_slice;
    import ptfb_pkg::*;

    localparam int NCELL = 9;
    localparam int CFG_W = $bits(cell_cfg_t);
    localparam logic [8:0] PRE = 9'h165;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_i = 1'b0, fclk0 = 1'b0, fclk1 = 1'b0;
    logic [PT_IN-1:0] x = '0;
    logic carry_i = 1'b0, carry_sel = 1'b0;
    logic [N_SH-1:0][PT_IN-1:0] sh_t, sh_c;
    cell_cfg_t cc [NCELL];
    logic [NCELL*CFG_W-1:0] cfg_flat;
    logic [NCELL-1:0] cell_o, oe_o, fb_o;
    logic carry_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCELL; i++) cfg_flat[i*CFG_W +: CFG_W] = cc[i];
    end

    ptfb_slice #(.NCELL(NCELL)) i_ptfb_slice (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .fclk0_i(fclk0), .fclk1_i(fclk1),
        .x_i(x), .carry_i(carry_i), .carry_sel_i(carry_sel),
        .sh_lit_t_i(sh_t), .sh_lit_c_i(sh_c), .cell_cfg_i(cfg_flat),
        .cell_o(cell_o), .oe_o(oe_o), .fb_o(fb_o), .carry_o(carry_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_base(input logic transp, input logic arith, input logic sub);
        sh_t = '0;
        sh_c = '0;
        for (int i = 0; i < NCELL; i++) begin
            cc[i] = '0;
            cc[i].lit_t[0][i]      = 1'b1;
            cc[i].lit_t[T_B][9+i]  = 1'b1;
            cc[i].transp  = transp;
            cc[i].arith   = arith;
            cc[i].sub     = sub;
            cc[i].lut     = 4'b1100;
            cc[i].ck_sel  = CK_NONE;
            cc[i].preload = PRE[i];
        end
    endtask

    task automatic comb_vec(input logic [23:0] v);
        @(negedge clk);
        x = v;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0] expq;
        logic [9:0] ref10;
        cfg_base(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < NCELL; i++) cc[i].ck_sel = CK_G0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9 reset clears", cell_o, 0);
        chk("R10 empty OE term", oe_o, 9'h1FF);

        // R9: init loads preload
        @(negedge clk); x = 24'h0001FF; init_i = 1'b1;
        @(negedge clk); init_i = 1'b0;
        chk("R9 init preload", cell_o, PRE);

        // R7: capture on fclk0, hold otherwise
        x = 24'h0000AA; fclk0 = 1'b1;
        @(negedge clk); fclk0 = 1'b0;
        chk("R7 capture fclk0", cell_o, 9'h0AA);
        x = 24'h000155;
        @(negedge clk);
        chk("R7 hold without clock", cell_o, 9'h0AA);

        // R7: per-cell clock selection
        for (int i = 0; i < NCELL; i++)
            cc[i].ck_sel = (i < 3) ? CK_G0 : (i < 6) ? CK_G1 : (i == 6) ? CK_TERM : CK_NONE;
        cc[6].lit_t[T_CLK][21] = 1'b1;
        expq = 9'h0AA;
        x = 24'h0001FF & 24'h000155 ^ 24'h0001FF; // 0x0AA inverted in low 9 bits
        x = 24'h000155;
        fclk1 = 1'b1;
        @(negedge clk); fclk1 = 1'b0;
        expq = (expq & ~9'h038) | (9'h155 & 9'h038);
        chk("R7 fclk1 cells", cell_o, expq);
        fclk0 = 1'b1;
        @(negedge clk); fclk0 = 1'b0;
        expq = (expq & ~9'h007) | (9'h155 & 9'h007);
        chk("R7 fclk0 cells", cell_o, expq);
        x = 24'h200155;
        @(negedge clk); x = 24'h000155;
        expq = (expq & ~9'h040) | (9'h155 & 9'h040);
        chk("R7 term clock cell", cell_o, expq);
        fclk0 = 1'b1; fclk1 = 1'b1;
        @(negedge clk); fclk0 = 1'b0; fclk1 = 1'b0;
        chk("R7 select none holds", cell_o[8:7], expq[8:7]);

        // R8: set / reset on cell 0
        for (int i = 0; i < NCELL; i++) cc[i].ck_sel = CK_NONE;
        cc[0].lit_t[T_SET][22] = 1'b1;
        cc[0].lit_t[T_RST][23] = 1'b1;
        x = 24'h800000; #1;
        chk("R8 reset immediate", cell_o[0], 0);
        x = 24'hC00000; #1;
        chk("R8 reset wins over set", cell_o[0], 0);
        @(negedge clk); x = 24'h000000; #1;
        chk("R8 reset written to register", cell_o[0], 0);
        x = 24'h400000; #1;
        chk("R8 set immediate", cell_o[0], 1);
        @(negedge clk); x = 24'h000000; #1;
        chk("R8 set written to register", cell_o[0], 1);

        // R10 / R11: output enable and feedback gating
        cc[0].lit_t[T_SET] = '0;
        cc[0].lit_t[T_RST] = '0;
        @(negedge clk); init_i = 1'b1;
        @(negedge clk); init_i = 1'b0;
        cc[1].lit_t[T_OE][20] = 1'b1; cc[1].fb_gate = 1'b1;
        cc[2].lit_t[T_OE][20] = 1'b1;
        cc[3].lit_t[T_OE][20] = 1'b1;
        x = 24'h000000; #1;
        chk("R10 OE term low", oe_o, 9'h1F1);
        chk("R11 gated fb high when disabled", fb_o[1], 1);
        chk("R11 cell1 output is low", cell_o[1], 0);
        chk("R11 ungated fb follows output", fb_o[3:2], 2'b01);
        x = 24'h100000; #1;
        chk("R10 OE term high", oe_o, 9'h1FF);
        chk("R11 enabled fb follows output", fb_o[1], 0);

        // R6 / R3: transparent add with carry from port
        cfg_base(1'b1, 1'b1, 1'b0);
        carry_sel = 1'b1;
        for (int a = 0; a < 512; a += 11) begin
            for (int b = 0; b < 512; b += 17) begin
                for (int c = 0; c < 2; c++) begin
                    carry_i = c[0];
                    comb_vec({6'd0, b[8:0], a[8:0]});
                    ref10 = 10'(a + b + c);
                    chk("R3 R5 R6 add", {carry_o, cell_o}, ref10);
                end
            end
        end
        carry_i = 1'b1;
        comb_vec({6'd0, 9'h1FF, 9'h1FF});
        chk("R3 add all ones", {carry_o, cell_o}, 10'h3FF);
        carry_i = 1'b0;
        comb_vec({6'd0, 9'h001, 9'h1FF});
        chk("R3 add wrap", {carry_o, cell_o}, 10'h200);
        carry_sel = 1'b0; carry_i = 1'b1;
        comb_vec({6'd0, 9'h000, 9'h0FF});
        chk("R3 carry_i ignored when not selected", {carry_o, cell_o}, 10'h0FF);

        // R4: subtract
        cfg_base(1'b1, 1'b1, 1'b1);
        carry_sel = 1'b0;
        for (int a = 0; a < 512; a += 11) begin
            for (int b = 0; b < 512; b += 17) begin
                comb_vec({6'd0, b[8:0], a[8:0]});
                ref10 = 10'(a + (~b & 511) + 1);
                chk("R4 R5 subtract", {carry_o, cell_o}, ref10);
            end
        end
        comb_vec({6'd0, 9'h0C3, 9'h0C3});
        chk("R4 equal operands", {carry_o, cell_o}, 10'h200);
        comb_vec({6'd0, 9'h001, 9'h000});
        chk("R4 borrow", {carry_o, cell_o}, 10'h1FF);

        // R2 / R5: logic mode truth tables, carry blocked
        cfg_base(1'b1, 1'b0, 1'b0);
        carry_sel = 1'b1; carry_i = 1'b1;
        for (int l = 0; l < 16; l++) begin
            for (int i = 0; i < NCELL; i++) cc[i].lut = l[3:0];
            for (int p = 0; p < 4; p++) begin
                comb_vec({6'd0, {9{p[0]}}, {9{p[1]}}});
                chk("R2 truth table", cell_o, {9{l[p]}});
                chk("R5 logic cells block carry", carry_o, 0);
            end
        end

        // R1: shared terms, complement literals, empty private terms
        cfg_base(1'b1, 1'b0, 1'b0);
        cc[0].lit_t[0] = '0;
        cc[0].lit_t[T_B] = '0;
        cc[0].a_sh[1] = 1'b1;
        cc[0].b_sh[2] = 1'b1;
        cc[0].lut = 4'b0110;
        sh_t[1][18] = 1'b1; sh_c[1][19] = 1'b1;
        sh_t[6][20] = 1'b1;
        sh_t[0][22] = 1'b1;
        for (int v = 0; v < 16; v++) begin
            comb_vec({1'b0, v[3], 1'b0, v[2], v[1], v[0], 18'd0});
            chk("R1 shared operand terms", cell_o[0], (v[0] & ~v[1]) ^ v[2]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule